// File: doc/BRIEF.md
# Flash Command Controller

This block sits in front of an on-chip non-volatile word array, which is modelled here as an internal memory, and runs operations on it through a small synchronous register bus. Software first loads a word address register and up to four data registers. It then writes an operation code to the command register. The controller accepts three operations: a single-word program, a four-word burst program and a page erase.

Progress is reported through a sticky raw status register. Writing 1 to a bit of that register clears the bit. A command that is accepted sets the started flag on the next clock edge. The done flag follows after a fixed busy interval. Because the interval is short, software that polls late can find both flags set at its first read. A command that is rejected never sets started. It raises either the illegal-command flag or the command-error flag instead, and it leaves the array untouched.

Programming can only clear bits. The new data is ANDed into the stored word. A page erase returns every word of the page to all ones. A read-only size register gives the highest valid word address, and a readback register returns the array word at the current address register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Register indices on `reg_i`: 0 address, 1 to 4 data lanes 0 to 3, 5 command, 6 status, 7 size (read-only), 8 readback. After reset the status and address registers read 0, and size reads NUM_WORDS-1 (1023 by default).
- R2: Status bits are: bit 0 started, bit 1 done, bit 2 illegal-command, bit 3 command-error. A write to the status register clears each bit whose written value is 1 and leaves every other bit unchanged. A flag being set in the same cycle wins over the clear.
- R3: For an accepted command, started is visible after the edge that writes the command. Done is visible BUSY_CYCLES edges later for a program command and PAGE_WORDS edges later for an erase. Both flags remain set until software clears them.
- R4: Code 0x01 programs one word at the address register with data lane 0. The stored word becomes old AND new.
- R5: Code 0x02 programs the four words at address+0 to address+3 from data lanes 0 to 3, each ANDed in. The address must be a multiple of four. A lane whose data is 0xFFFFFFFF is skipped.
- R6: Code 0x03 erases the page selected by address bits [16:9], so that every word of that page reads 0xFFFFFFFF. No other page changes.
- R7: The following raise illegal-command: an unknown code, a burst whose address is not a multiple of four, and an erase whose address bits [8:0] are not zero. In each case started stays clear and no word changes.
- R8: A known, well-formed command whose address is above the size value raises command-error. Started stays clear and no word changes.
- R9: A command written while another is running raises command-error. The running command completes with the address and data it captured at launch, even if the address or data registers are rewritten in the meantime.
- R10: The readback register returns, in the same cycle, the array word at the current address. It returns 0 for an address above the size value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| reg_i | input | 4 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `reg_i` |

## Verification
Register writes and error flags take effect at the edge that carries the write. The bench therefore drives each access on a falling edge and reads at the next falling edge, which is one register stage later. For the command timing, the bench counts falling edges after the launch. It expects done to be clear at edge BUSY_CYCLES-1, or PAGE_WORDS-1 for an erase, and set at the following edge. Readback is combinational, so the bench sets the address, waits one edge for it to register, and then compares the word against a model array that it updates arithmetically with AND and erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int LANES = 4;

  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_BURST = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h03;

  localparam int ST_START = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_ILL   = 2;
  localparam int ST_ERR   = 3;

  localparam logic [3:0] RG_ADDR = 4'd0;
  localparam logic [3:0] RG_D0   = 4'd1;
  localparam logic [3:0] RG_CMD  = 4'd5;
  localparam logic [3:0] RG_STAT = 4'd6;
  localparam logic [3:0] RG_SIZE = 4'd7;
  localparam logic [3:0] RG_RDAT = 4'd8;
endpackage

// File: rtl/fcc_check.sv
module fcc_check
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 17,
  parameter int PAGE_W    = 9,
  parameter int NUM_WORDS = 1024
) (
  input  logic          cmd_wr_i,
  input  logic [7:0]    code_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_i,
  output logic          launch_o,
  output logic          ill_o,
  output logic          err_o
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(NUM_WORDS - 1);

  logic known, misal;

  always_comb begin
    known = (code_i == OP_WRITE) || (code_i == OP_BURST) || (code_i == OP_ERASE);
    misal = ((code_i == OP_BURST) && (addr_i[1:0] != 2'b00)) ||
            ((code_i == OP_ERASE) && (addr_i[PAGE_W-1:0] != '0));
    launch_o = 1'b0;
    ill_o    = 1'b0;
    err_o    = 1'b0;
    if (cmd_wr_i) begin
      if (busy_i)                 err_o    = 1'b1;
      else if (!known || misal)   ill_o    = 1'b1;
      else if (addr_i > TOP_ADDR) err_o    = 1'b1;
      else                        launch_o = 1'b1;
    end
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 32,
  parameter int PAGE_W      = 9,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     launch_i,
  input  logic [7:0]               op_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [LANES-1:0][DW-1:0] data_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     prog_en_o,
  output logic [LANES-1:0]         lane_o,
  output logic [AW-1:0]            prog_addr_o,
  output logic [LANES-1:0][DW-1:0] prog_data_o,
  output logic                     erase_en_o,
  output logic [AW-1:0]            erase_addr_o
);
  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int MAX_CNT    = (PAGE_WORDS > BUSY_CYCLES) ? PAGE_WORDS : BUSY_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CNT) + 1;

  logic                     busy_q;
  logic [7:0]               op_q;
  logic [AW-1:0]            addr_q;
  logic [LANES-1:0][DW-1:0] data_q;
  logic [CNT_W-1:0]         cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      addr_q <= addr_i;
      data_q <= data_i;
      cnt_q  <= (op_i == OP_ERASE) ? CNT_W'(PAGE_WORDS - 1) : CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = busy_q && (cnt_q == '0);
  assign prog_en_o    = done_o && (op_q != OP_ERASE);
  assign prog_addr_o  = addr_q;
  assign prog_data_o  = data_q;
  // erase walks one word per cycle, downward from the page top
  assign erase_en_o   = busy_q && (op_q == OP_ERASE);
  assign erase_addr_o = addr_q + AW'(cnt_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_o[l] = (op_q == OP_BURST) ? (data_q[l] != '1) : 1'(l == 0);
  end
endmodule

// File: rtl/fcc_array.sv
module fcc_array
  import flash_cmd_pkg::*;
#(
  parameter int DW        = 32,
  parameter int NUM_WORDS = 1024,
  localparam int IW       = $clog2(NUM_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     prog_en_i,
  input  logic [LANES-1:0]         lane_i,
  input  logic [IW-1:0]            prog_addr_i,
  input  logic [LANES-1:0][DW-1:0] prog_data_i,
  input  logic                     erase_en_i,
  input  logic [IW-1:0]            erase_addr_i,
  input  logic [IW-1:0]            rd_addr_i,
  output logic [DW-1:0]            rd_data_o
);
  logic [DW-1:0] mem [NUM_WORDS];
  logic [LANES-1:0][IW-1:0] lane_idx;

  always_comb begin
    for (int l = 0; l < LANES; l++) lane_idx[l] = prog_addr_i + IW'(l);
  end

  always_ff @(posedge clk_i) begin
    if (erase_en_i) mem[erase_addr_i] <= '1;
    if (prog_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_i[l]) mem[lane_idx[l]] <= mem[lane_idx[l]] & prog_data_i[l];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 32,
  parameter int PAGE_W      = 9,
  parameter int NUM_WORDS   = 1024,
  parameter int BUSY_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [3:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int IW = $clog2(NUM_WORDS);
  localparam logic [AW-1:0] TOP_ADDR = AW'(NUM_WORDS - 1);

  logic [AW-1:0]            addr_q;
  logic [LANES-1:0][DW-1:0] data_q;
  logic [3:0]               stat_q;

  logic wr, cmd_wr, stat_wr;
  logic launch, ill, err, busy, done_evt;
  logic prog_en, erase_en;
  logic [LANES-1:0]         lane;
  logic [AW-1:0]            prog_addr, erase_addr;
  logic [LANES-1:0][DW-1:0] prog_data;
  logic [DW-1:0]            mem_rd;

  assign wr      = req_i && we_i;
  assign cmd_wr  = wr && (reg_i == RG_CMD);
  assign stat_wr = wr && (reg_i == RG_STAT);

  fcc_check #(.AW(AW), .PAGE_W(PAGE_W), .NUM_WORDS(NUM_WORDS)) u_check (
    .cmd_wr_i (cmd_wr),
    .code_i   (wdata_i[7:0]),
    .addr_i   (addr_q),
    .busy_i   (busy),
    .launch_o (launch),
    .ill_o    (ill),
    .err_o    (err)
  );

  fcc_seq #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .op_i         (wdata_i[7:0]),
    .addr_i       (addr_q),
    .data_i       (data_q),
    .busy_o       (busy),
    .done_o       (done_evt),
    .prog_en_o    (prog_en),
    .lane_o       (lane),
    .prog_addr_o  (prog_addr),
    .prog_data_o  (prog_data),
    .erase_en_o   (erase_en),
    .erase_addr_o (erase_addr)
  );

  fcc_array #(.DW(DW), .NUM_WORDS(NUM_WORDS)) u_array (
    .clk_i        (clk_i),
    .prog_en_i    (prog_en),
    .lane_i       (lane),
    .prog_addr_i  (prog_addr[IW-1:0]),
    .prog_data_i  (prog_data),
    .erase_en_i   (erase_en),
    .erase_addr_i (erase_addr[IW-1:0]),
    .rd_addr_i    (addr_q[IW-1:0]),
    .rd_data_o    (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr && (reg_i == RG_ADDR)) addr_q <= wdata_i[AW-1:0];
      for (int l = 0; l < LANES; l++) begin
        if (wr && (reg_i == RG_D0 + 4'(l))) data_q[l] <= wdata_i;
      end
      // set beats clear
      stat_q <= (stat_q & ~(stat_wr ? wdata_i[3:0] : 4'b0)) | {err, ill, done_evt, launch};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_i == RG_ADDR)      rdata_o = DW'(addr_q);
    else if (reg_i == RG_STAT) rdata_o = DW'(stat_q);
    else if (reg_i == RG_SIZE) rdata_o = DW'(TOP_ADDR);
    else if (reg_i == RG_RDAT) rdata_o = (addr_q > TOP_ADDR) ? '0 : mem_rd;
    else begin
      for (int l = 0; l < LANES; l++) begin
        if (reg_i == RG_D0 + 4'(l)) rdata_o = data_q[l];
      end
    end
  end
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_wr_i,
  input logic       stat_wr_i,
  input logic [3:0] clr_i,
  input logic       busy_i,
  input logic       last_i,
  input logic       launch_i,
  input logic [3:0] stat_i
);
  // R9
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy_i |=> stat_i[ST_ERR]);

  // R9
  run_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy_i && !last_i |=> busy_i);

  // R2
  w1c_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && clr_i[ST_DONE] && !last_i |=> !stat_i[ST_DONE]);

  // R3
  done_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i && !stat_i[ST_DONE] |=> !stat_i[ST_DONE]);

  // R7
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !launch_i && !stat_i[ST_START] |=> !stat_i[ST_START]);

  // R3
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_i && stat_i[ST_START]);
endmodule

bind flash_cmd_ctrl fcc_chk u_fcc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_wr_i  (cmd_wr),
  .stat_wr_i (stat_wr),
  .clr_i     (wdata_i[3:0]),
  .busy_i    (busy),
  .last_i    (done_evt),
  .launch_i  (launch),
  .stat_i    (stat_q)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int NW = 1024;
  localparam int PW = 512;
  localparam int BC = 4;
  localparam logic [3:0] A_ADDR = 0, A_CMD = 5, A_STAT = 6, A_SIZE = 7, A_RDAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  reg_s = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;

  int nvec = 0, nerr = 0;
  bit finished = 1'b0;
  logic [31:0] model [NW];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.NUM_WORDS(NW), .BUSY_CYCLES(BC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .reg_i(reg_s), .wdata_i(wd), .rdata_o(rdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; reg_s = r; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] r, output logic [31:0] v);
    reg_s = r;
    #1 v = rdata;
  endtask

  task automatic wait_done_clear();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, s);
      if (s[1]) break;
      @(negedge clk);
    end
    chk("R3 done reached", {31'b0, s[1]}, 32'd1);
    wr(A_STAT, 32'hF);
  endtask

  task automatic readback(input string rq);
    logic [31:0] v;
    for (int i = 0; i < NW; i++) begin
      wr(A_ADDR, i);
      rd(A_RDAT, v);
      chk(rq, v, model[i]);
    end
  endtask

  task automatic erase(input int page, input bit timed);
    logic [31:0] s;
    wr(A_ADDR, page * PW);
    wr(A_CMD, 32'h3);
    if (timed) begin
      rd(A_STAT, s);
      chk("R3 erase started", s, 32'h1);
      for (int k = 1; k <= PW; k++) begin
        @(negedge clk);
        rd(A_STAT, s);
        if (k >= PW - 1) chk("R3 erase done edge", s, (k == PW) ? 32'h3 : 32'h1);
      end
    end
    wait_done_clear();
    for (int i = 0; i < PW; i++) model[page * PW + i] = 32'hFFFF_FFFF;
  endtask

  task automatic single(input int a, input logic [31:0] d, input bit timed);
    logic [31:0] s;
    wr(A_ADDR, a);
    wr(4'd1, d);
    wr(A_CMD, 32'h1);
    if (timed) begin
      rd(A_STAT, s);
      chk("R3 write started", s, 32'h1);
      for (int k = 1; k <= BC; k++) begin
        @(negedge clk);
        rd(A_STAT, s);
        chk("R3 write done edge", s, (k == BC) ? 32'h3 : 32'h1);
      end
    end
    wait_done_clear();
    model[a] = model[a] & d;
  endtask

  task automatic expect_reject(input logic [31:0] code, input logic [31:0] st, input string rq);
    logic [31:0] s;
    wr(A_CMD, code);
    rd(A_STAT, s);
    chk(rq, s, st);
    @(negedge clk);
    rd(A_STAT, s);
    chk(rq, s, st);
    wr(A_STAT, 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] d [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); chk("R1 status reset", v, 0);
    rd(A_ADDR, v); chk("R1 addr reset", v, 0);
    rd(A_SIZE, v); chk("R1 size", v, NW - 1);

    // R6 erase, exact done edge
    erase(0, 1'b1);
    erase(1, 1'b0);
    readback("R6 erased");

    // R4 single writes, AND semantics
    for (int i = 0; i < 16; i++) begin
      single(i * 61 + 3, 32'hA5A5_0F0F ^ (i * 32'h0101_0101), i == 0);
      single(i * 61 + 3, ~(32'h1 << i), 1'b0);
    end

    // R5 burst lane sweep, all-ones lanes skipped
    for (int m = 0; m < 16; m++) begin
      int base = 600 + 4 * m;
      for (int l = 0; l < 4; l++)
        d[l] = m[l] ? 32'hFFFF_FFFF : (32'h1234_5678 + m * 32'h0011_0000 + l);
      wr(A_ADDR, base);
      for (int l = 0; l < 4; l++) wr(4'(l + 1), d[l]);
      wr(A_CMD, 32'h2);
      wait_done_clear();
      for (int l = 0; l < 4; l++) if (d[l] != 32'hFFFF_FFFF) model[base + l] = model[base + l] & d[l];
    end
    // R5 burst over already programmed words
    wr(A_ADDR, 64);
    for (int l = 0; l < 4; l++) begin
      d[l] = 32'h0F0F_F0F0 >> l;
      wr(4'(l + 1), d[l]);
    end
    wr(A_CMD, 32'h2);
    wait_done_clear();
    for (int l = 0; l < 4; l++) model[64 + l] = model[64 + l] & d[l];
    readback("R5 burst");

    // R7 illegal cases
    expect_reject(32'h07, 32'h4, "R7 unknown code");
    expect_reject(32'h00, 32'h4, "R7 zero code");
    wr(A_ADDR, 602);
    expect_reject(32'h2, 32'h4, "R7 misaligned burst");
    wr(A_ADDR, 513);
    expect_reject(32'h3, 32'h4, "R7 erase low bits");

    // R8 out of range
    wr(A_ADDR, NW);
    rd(A_RDAT, v); chk("R10 readback beyond size", v, 0);
    expect_reject(32'h1, 32'h8, "R8 write beyond size");
    wr(A_ADDR, 32'h1FE00);
    expect_reject(32'h3, 32'h8, "R8 erase beyond size");

    // R9 command while busy, address changed mid-run
    wr(A_ADDR, 100);
    wr(4'd1, 32'h0000_FFFF);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    rd(A_STAT, v); chk("R9 busy reject flags", v, 32'h9);
    wr(A_ADDR, 200);
    wr(4'd1, 32'h0);
    wait_done_clear();
    model[100] = model[100] & 32'h0000_FFFF;
    wr(A_ADDR, 100); rd(A_RDAT, v); chk("R9 running cmd kept", v, model[100]);
    wr(A_ADDR, 200); rd(A_RDAT, v); chk("R9 new addr untouched", v, model[200]);

    // R2 W1C per bit
    single(5, 32'hFFFF_0000, 1'b0);
    wr(A_ADDR, 6); wr(4'd1, 32'h0); wr(A_CMD, 32'h1);
    repeat (BC + 1) @(negedge clk);
    rd(A_STAT, v); chk("R2 both flags", v, 32'h3);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R2 clear done only", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R2 clear started", v, 32'h0);
    model[6] = 32'h0;

    // R6 erase page 0 again, page 1 preserved
    erase(0, 1'b0);
    readback("R6 page erase isolation");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule